// File: doc/BRIEF.md
# Command Ring Fetch Pointer Controller

This block sits between a host that fills a circular command buffer and a command processor that drains it. The host writes a write pointer, and can preload a shadow read pointer. From the live read pointer up to the write pointer, the block issues memory read requests. It counts out the returned dwords, advances the read pointer and wraps it at the end of the ring. Each returned dword can pass through a byte-lane swap, and the block periodically asks to copy its read pointer into a host-memory mirror.

Both pointers are dword indices within a ring whose size comes from a log2 code. Each request is the smallest of three amounts: the configured burst cap, the dwords left before the wrap point, and the dwords available up to the write pointer. Only one request is outstanding at a time. The request, the swapped data and the write-back request all leave the block from registers.

Top module: `cmd_ring_fetch`

## Requirements
- R1: The ring holds 2^(c+1) dwords for size code c in 2..22. Codes 0 and 1 give 8 dwords, and codes above 22 give 2^23 dwords. Pointers wrap modulo this size.
- R2: When the read pointer equals the write pointer, no request is raised.
- R3: A request carries the read pointer as `req_addr`. Its `req_len` is min(burst cap, dwords before the wrap, dwords available), so no request crosses the wrap point.
- R4: Burst code 0, 1, 2 or 3 caps `req_len` at 8, 16, 32 or 64 dwords (32 to 256 bytes).
- R5: With `ctl_sysmem`=1, each response dword 0xAABBCCDD is output one cycle later as follows. Swap code 0 leaves it unchanged. Code 1 gives 0xBBAADDCC, code 2 gives 0xDDCCBBAA and code 3 gives 0xCCDDAABB.
- R6: With `ctl_sysmem`=0, response data passes through unchanged whatever the swap code.
- R7: The read pointer, visible on `rptr_o`, advances by one per accepted response dword, modulo the ring size.
- R8: Once 2^b quadwords (2^(b+1) dwords) have been consumed for block code b, `wb_valid` rises with `wb_ptr` equal to the read pointer after that dword. It stays high until `wb_ready` is seen. A later boundary refreshes `wb_ptr`.
- R9: With `ctl_wb_off`=1, `wb_valid` never rises.
- R10: With `ctl_shadow_en`=1, a write-pointer write also loads the stored shadow value into the read pointer. With it 0, the read pointer is untouched.
- R11: Synchronous reset clears both pointers and the interval count, and drops `req_valid`, `out_valid` and `wb_valid`.
- R12: While `req_valid` is high and `req_ready` is low, the request and its address and length hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_size_code | input | 6 | Log2 ring size code |
| ctl_blk_code | input | 6 | Log2 write-back interval in quadwords |
| ctl_burst | input | 2 | Burst cap code |
| ctl_swap | input | 2 | Byte-lane swap mode |
| ctl_sysmem | input | 1 | Ring lives in system memory (enables swap) |
| ctl_wb_off | input | 1 | Suppress read-pointer write-back |
| ctl_shadow_en | input | 1 | Copy shadow into read pointer on write-pointer write |
| wptr_we | input | 1 | Write-pointer write strobe |
| wptr_wdata | input | 23 | New write pointer |
| shadow_we | input | 1 | Shadow read-pointer write strobe |
| shadow_wdata | input | 23 | New shadow value |
| req_valid | output | 1 | Read request pending |
| req_ready | input | 1 | Request accepted |
| req_addr | output | 23 | Start dword index of request |
| req_len | output | 7 | Request length in dwords |
| rsp_valid | input | 1 | Response dword valid |
| rsp_data | input | 32 | Response dword |
| out_valid | output | 1 | Swapped dword valid |
| out_data | output | 32 | Swapped dword |
| wb_valid | output | 1 | Write-back request pending |
| wb_ready | input | 1 | Write-back accepted |
| wb_ptr | output | 23 | Read pointer to write back |
| rptr_o | output | 23 | Live read pointer |

## Verification
A wrong read pointer shows up on the next `req_addr`, one cycle after the current burst ends, and it shows on `rptr_o` at once. A miscomputed ring mask or wrap distance gives a `req_len` that runs past the ring end, or an address that fails to return to zero. Both are visible at the first request near the wrap. A wrong interval count shows as `wb_valid` rising early, late or with a stale `wb_ptr`, within one interval of dwords. A wrong swap shows on `out_data` one cycle after the response.

// File: rtl/cmd_ring_pkg.sv
package cmd_ring_pkg;

  typedef enum logic [1:0] {
    SW_NONE   = 2'd0,
    SW_BYTE16 = 2'd1,
    SW_FULL   = 2'd2,
    SW_HALVES = 2'd3
  } swap_mode_e;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_REQ  = 2'd1,
    FS_DATA = 2'd2
  } fetch_state_e;

  function automatic logic [31:0] word_swap(input logic [31:0] d, input swap_mode_e m);
    case (m)
      SW_BYTE16: word_swap = {d[23:16], d[31:24], d[7:0], d[15:8]};
      SW_FULL:   word_swap = {d[7:0], d[15:8], d[23:16], d[31:24]};
      SW_HALVES: word_swap = {d[15:0], d[31:16]};
      default:   word_swap = d;
    endcase
  endfunction

endpackage

// File: rtl/crf_ring_geom.sv
module crf_ring_geom #(
  parameter int FIELD_W  = 6,
  parameter int MIN_CODE = 2,
  parameter int MAX_CODE = 22,
  localparam int PTR_W   = MAX_CODE + 1
) (
  input  logic [FIELD_W-1:0] size_code,
  output logic [PTR_W:0]     size_dw,
  output logic [PTR_W-1:0]   mask
);
  logic [FIELD_W-1:0] eff;
  logic [PTR_W:0]     full;

  always_comb begin
    if (size_code < FIELD_W'(MIN_CODE))      eff = FIELD_W'(MIN_CODE);
    else if (size_code > FIELD_W'(MAX_CODE)) eff = FIELD_W'(MAX_CODE);
    else                                     eff = size_code;
    full = (PTR_W+1)'(1) << (eff + FIELD_W'(1));
  end

  assign size_dw = full;
  assign mask    = PTR_W'(full - (PTR_W+1)'(1));
endmodule

// File: rtl/crf_lane_swap.sv
module crf_lane_swap
  import cmd_ring_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int WORDS = DATA_W / 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [1:0]        mode,
  input  logic              enable,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  logic [DATA_W-1:0] swapped;

  genvar w;
  generate
    for (w = 0; w < WORDS; w++) begin : g_word
      assign swapped[w*32 +: 32] = enable ? word_swap(in_data[w*32 +: 32], swap_mode_e'(mode))
                                          : in_data[w*32 +: 32];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= swapped;
    end
  end
endmodule

// File: rtl/crf_wb_timer.sv
module crf_wb_timer #(
  parameter int PTR_W   = 23,
  parameter int FIELD_W = 6,
  localparam int CNT_W  = PTR_W + 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               beat,
  input  logic [PTR_W-1:0]   new_ptr,
  input  logic [FIELD_W-1:0] blk_code,
  input  logic               wb_off,
  input  logic               wb_ready,
  output logic               wb_valid,
  output logic [PTR_W-1:0]   wb_ptr
);
  logic [FIELD_W-1:0] blk_eff;
  logic [CNT_W-1:0]   interval;
  logic [CNT_W-1:0]   cnt_q;
  logic               hit;

  always_comb begin
    blk_eff  = (blk_code > FIELD_W'(PTR_W)) ? FIELD_W'(PTR_W) : blk_code;
    interval = CNT_W'(1) << (blk_eff + FIELD_W'(1));
    hit      = beat && ((cnt_q + CNT_W'(1)) == interval);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      wb_valid <= 1'b0;
      wb_ptr   <= '0;
    end else begin
      if (hit)       cnt_q <= '0;
      else if (beat) cnt_q <= cnt_q + CNT_W'(1);

      if (hit && !wb_off) begin
        wb_valid <= 1'b1;
        wb_ptr   <= new_ptr;
      end else if (wb_ready) begin
        wb_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cmd_ring_fetch.sv
module cmd_ring_fetch
  import cmd_ring_pkg::*;
#(
  parameter int FIELD_W      = 6,
  parameter int MIN_CODE     = 2,
  parameter int MAX_CODE     = 22,
  parameter int MIN_BURST_DW = 8,
  parameter int BURST_CODES  = 4,
  parameter int DATA_W       = 32,
  localparam int PTR_W        = MAX_CODE + 1,
  localparam int MAX_BURST_DW = MIN_BURST_DW << (BURST_CODES - 1),
  localparam int LEN_W        = $clog2(MAX_BURST_DW) + 1,
  localparam int BC_W         = $clog2(BURST_CODES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [FIELD_W-1:0] ctl_size_code,
  input  logic [FIELD_W-1:0] ctl_blk_code,
  input  logic [BC_W-1:0]    ctl_burst,
  input  logic [1:0]         ctl_swap,
  input  logic               ctl_sysmem,
  input  logic               ctl_wb_off,
  input  logic               ctl_shadow_en,
  input  logic               wptr_we,
  input  logic [PTR_W-1:0]   wptr_wdata,
  input  logic               shadow_we,
  input  logic [PTR_W-1:0]   shadow_wdata,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [PTR_W-1:0]   req_addr,
  output logic [LEN_W-1:0]   req_len,
  input  logic               rsp_valid,
  input  logic [DATA_W-1:0]  rsp_data,
  output logic               out_valid,
  output logic [DATA_W-1:0]  out_data,
  output logic               wb_valid,
  input  logic               wb_ready,
  output logic [PTR_W-1:0]   wb_ptr,
  output logic [PTR_W-1:0]   rptr_o
);
  logic [PTR_W:0]     size_dw;
  logic [PTR_W-1:0]   mask;
  logic [PTR_W-1:0]   rptr_q, wptr_q, shadow_q, rptr_inc;
  logic [PTR_W-1:0]   avail;
  logic [PTR_W:0]     to_wrap, cap_dw, m1, m2;
  logic [LEN_W-1:0]   len_next, beats_left;
  fetch_state_e       state_q;
  logic               beat;

  crf_ring_geom #(
    .FIELD_W (FIELD_W),
    .MIN_CODE(MIN_CODE),
    .MAX_CODE(MAX_CODE)
  ) u_geom (
    .size_code(ctl_size_code),
    .size_dw  (size_dw),
    .mask     (mask)
  );

  always_comb begin
    avail    = (wptr_q - rptr_q) & mask;
    to_wrap  = size_dw - {1'b0, rptr_q};
    cap_dw   = (PTR_W+1)'(MIN_BURST_DW) << ctl_burst;
    m1       = (cap_dw < to_wrap) ? cap_dw : to_wrap;
    m2       = (m1 < {1'b0, avail}) ? m1 : {1'b0, avail};
    len_next = LEN_W'(m2);
    beat     = (state_q == FS_DATA) && rsp_valid;
    rptr_inc = (rptr_q + PTR_W'(1)) & mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q   <= '0;
      rptr_q   <= '0;
      shadow_q <= '0;
    end else begin
      if (shadow_we) shadow_q <= shadow_wdata;
      if (wptr_we)   wptr_q   <= wptr_wdata & mask;
      if (wptr_we && ctl_shadow_en) rptr_q <= shadow_q & mask;
      else if (beat)                rptr_q <= rptr_inc;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= FS_IDLE;
      req_valid  <= 1'b0;
      req_addr   <= '0;
      req_len    <= '0;
      beats_left <= '0;
    end else begin
      case (state_q)
        FS_IDLE: if (avail != '0) begin
          req_valid <= 1'b1;
          req_addr  <= rptr_q;
          req_len   <= len_next;
          state_q   <= FS_REQ;
        end
        FS_REQ: if (req_ready) begin
          req_valid  <= 1'b0;
          beats_left <= req_len;
          state_q    <= FS_DATA;
        end
        FS_DATA: if (rsp_valid) begin
          beats_left <= beats_left - LEN_W'(1);
          if (beats_left == LEN_W'(1)) state_q <= FS_IDLE;
        end
        default: state_q <= FS_IDLE;
      endcase
    end
  end

  crf_lane_swap #(.DATA_W(DATA_W)) u_swap (
    .clk      (clk),
    .rst      (rst),
    .in_valid (beat),
    .in_data  (rsp_data),
    .mode     (ctl_swap),
    .enable   (ctl_sysmem),
    .out_valid(out_valid),
    .out_data (out_data)
  );

  crf_wb_timer #(.PTR_W(PTR_W), .FIELD_W(FIELD_W)) u_wb (
    .clk     (clk),
    .rst     (rst),
    .beat    (beat),
    .new_ptr (rptr_inc),
    .blk_code(ctl_blk_code),
    .wb_off  (ctl_wb_off),
    .wb_ready(wb_ready),
    .wb_valid(wb_valid),
    .wb_ptr  (wb_ptr)
  );

  assign rptr_o = rptr_q;
endmodule

// File: rtl/cmd_ring_fetch_chk.sv
module cmd_ring_fetch_chk #(
  parameter int PTR_W        = 23,
  parameter int LEN_W        = 7,
  parameter int BC_W         = 2,
  parameter int MIN_BURST_DW = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [BC_W-1:0]  ctl_burst,
  input logic             ctl_wb_off,
  input logic             ctl_shadow_en,
  input logic             wptr_we,
  input logic             req_valid,
  input logic             req_ready,
  input logic [PTR_W-1:0] req_addr,
  input logic [LEN_W-1:0] req_len,
  input logic             rsp_valid,
  input logic             out_valid,
  input logic             wb_valid,
  input logic             wb_ready,
  input logic [PTR_W-1:0] rptr_q,
  input logic [PTR_W-1:0] wptr_q,
  input logic [PTR_W-1:0] shadow_q,
  input logic [PTR_W-1:0] mask
);
  logic [LEN_W:0] cap_c;
  assign cap_c = (LEN_W+1)'(MIN_BURST_DW) << ctl_burst;

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_len));

  // R4
  req_cap_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (req_len != '0) && ({1'b0, req_len} <= cap_c));

  // R2
  empty_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(req_valid) |-> $past(wptr_q != rptr_q));

  // R8
  wb_hold_chk: assert property (@(posedge clk) disable iff (rst)
    wb_valid && !wb_ready |=> wb_valid);

  // R9
  wb_off_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wb_valid) |-> !$past(ctl_wb_off));

  // R7
  out_src_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(rsp_valid));

  // R10
  shadow_load_chk: assert property (@(posedge clk) disable iff (rst)
    $past(wptr_we && ctl_shadow_en) |-> rptr_q == ($past(shadow_q) & $past(mask)));
endmodule

bind cmd_ring_fetch cmd_ring_fetch_chk #(
  .PTR_W(PTR_W), .LEN_W(LEN_W), .BC_W(BC_W), .MIN_BURST_DW(MIN_BURST_DW)
) u_chk (
  .clk(clk), .rst(rst), .ctl_burst(ctl_burst), .ctl_wb_off(ctl_wb_off),
  .ctl_shadow_en(ctl_shadow_en), .wptr_we(wptr_we), .req_valid(req_valid),
  .req_ready(req_ready), .req_addr(req_addr), .req_len(req_len),
  .rsp_valid(rsp_valid), .out_valid(out_valid), .wb_valid(wb_valid),
  .wb_ready(wb_ready), .rptr_q(rptr_q), .wptr_q(wptr_q), .shadow_q(shadow_q),
  .mask(mask)
);

// File: tb/cmd_ring_fetch_bench.sv
module cmd_ring_fetch_bench;
  localparam int PW = 23;
  localparam int LW = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] ctl_size_code = 6'd4, ctl_blk_code = 6'd20;
  logic [1:0] ctl_burst = 2'd0, ctl_swap = 2'd0;
  logic ctl_sysmem = 1'b0, ctl_wb_off = 1'b0, ctl_shadow_en = 1'b0;
  logic wptr_we = 1'b0, shadow_we = 1'b0;
  logic [PW-1:0] wptr_wdata = '0, shadow_wdata = '0;
  logic req_valid, req_ready = 1'b0;
  logic [PW-1:0] req_addr, wb_ptr, rptr_o;
  logic [LW-1:0] req_len;
  logic rsp_valid = 1'b0;
  logic [31:0] rsp_data = '0, out_data;
  logic out_valid, wb_valid, wb_ready = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  cmd_ring_fetch u_cmd_ring_fetch (
    .clk(clk), .rst(rst), .ctl_size_code(ctl_size_code), .ctl_blk_code(ctl_blk_code),
    .ctl_burst(ctl_burst), .ctl_swap(ctl_swap), .ctl_sysmem(ctl_sysmem),
    .ctl_wb_off(ctl_wb_off), .ctl_shadow_en(ctl_shadow_en), .wptr_we(wptr_we),
    .wptr_wdata(wptr_wdata), .shadow_we(shadow_we), .shadow_wdata(shadow_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_len(req_len),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .out_valid(out_valid), .out_data(out_data),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_ptr(wb_ptr), .rptr_o(rptr_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int x);
    logic [7:0] b = 8'(x);
    return {8'hA0 ^ b, 8'hB1, 8'hC2, b};
  endfunction

  function automatic logic [31:0] model(input logic [31:0] d);
    if (!ctl_sysmem) return d;
    case (ctl_swap)
      2'd1:    return {d[23:16], d[31:24], d[7:0], d[15:8]};
      2'd2:    return {d[7:0], d[15:8], d[23:16], d[31:24]};
      2'd3:    return {d[15:0], d[31:16]};
      default: return d;
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    ctl_size_code = 6'd4; ctl_blk_code = 6'd20; ctl_burst = 2'd0; ctl_swap = 2'd0;
    ctl_sysmem = 1'b0; ctl_wb_off = 1'b0; ctl_shadow_en = 1'b0;
    req_ready = 1'b0; rsp_valid = 1'b0; wb_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic write_wptr(input logic [PW-1:0] v);
    wptr_we = 1'b1; wptr_wdata = v;
    @(negedge clk);
    wptr_we = 1'b0;
  endtask

  task automatic write_shadow(input logic [PW-1:0] v);
    shadow_we = 1'b1; shadow_wdata = v;
    @(negedge clk);
    shadow_we = 1'b0;
  endtask

  task automatic fetch_one(input logic [PW-1:0] ea, input int elen, input string tag, input int stall);
    int t = 0;
    while (!req_valid && t < 200) begin @(negedge clk); t++; end
    chk({tag, " req_valid"}, {31'b0, req_valid}, 32'd1);
    chk({tag, " req_addr"}, 32'(req_addr), 32'(ea));
    chk({tag, " req_len"}, 32'(req_len), 32'(elen));
    if (stall > 0) begin
      repeat (stall) @(negedge clk);
      chk("R12 request held", {31'b0, req_valid}, 32'd1);
      chk("R12 address held", 32'(req_addr), 32'(ea));
    end
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    for (int i = 0; i < elen; i++) begin
      rsp_valid = 1'b1;
      rsp_data  = pat(int'(ea) + i);
      @(negedge clk);
      chk({tag, " R7 out_valid"}, {31'b0, out_valid}, 32'd1);
      chk({tag, " R5/R6 out_data"}, out_data, model(pat(int'(ea) + i)));
    end
    rsp_valid = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R11 req_valid", {31'b0, req_valid}, 32'd0);
    chk("R11 out_valid", {31'b0, out_valid}, 32'd0);
    chk("R11 wb_valid", {31'b0, wb_valid}, 32'd0);
    chk("R11 rptr", 32'(rptr_o), 32'd0);
  endtask

  task automatic t_empty();
    bit seen = 1'b0;
    do_reset();
    ctl_size_code = 6'd0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (req_valid) seen = 1'b1;
    end
    chk("R2 no request on empty ring", {31'b0, seen}, 32'd0);
  endtask

  task automatic t_basic();
    do_reset();
    write_wptr(23'd5);
    fetch_one(23'd0, 5, "R3 first", 0);
    chk("R7 rptr after 5", 32'(rptr_o), 32'd5);
    write_wptr(23'd30);
    fetch_one(23'd5, 8, "R3 capped", 3);
    ctl_burst = 2'd1;
    fetch_one(23'd13, 16, "R3 second", 0);
    fetch_one(23'd29, 1, "R3 avail-limited", 0);
    chk("R7 rptr at 30", 32'(rptr_o), 32'd30);
    write_wptr(23'd2);
    fetch_one(23'd30, 2, "R3 wrap-limited", 0);
    fetch_one(23'd0, 2, "R3 after wrap", 0);
    chk("R7 rptr wrapped", 32'(rptr_o), 32'd2);
  endtask

  task automatic t_burst();
    do_reset();
    ctl_size_code = 6'd10;
    ctl_burst = 2'd3;
    write_wptr(23'd200);
    fetch_one(23'd0, 64, "R4 code3", 0);
    ctl_burst = 2'd2;
    fetch_one(23'd64, 32, "R4 code2", 0);
    ctl_burst = 2'd1;
    fetch_one(23'd96, 16, "R4 code1", 0);
    ctl_burst = 2'd0;
    fetch_one(23'd112, 8, "R4 code0", 0);
  endtask

  task automatic t_clamp();
    do_reset();
    ctl_size_code = 6'd1;
    write_wptr(23'd6);
    fetch_one(23'd0, 6, "R1 small ring", 0);
    write_wptr(23'd3);
    fetch_one(23'd6, 2, "R1 small wrap", 0);
    fetch_one(23'd0, 3, "R1 small after wrap", 0);
    do_reset();
    ctl_size_code = 6'd40;
    ctl_shadow_en = 1'b1;
    write_shadow(23'h7FFFFC);
    write_wptr(23'd4);
    chk("R1 large ring rptr", 32'(rptr_o), 32'h7FFFFC);
    fetch_one(23'h7FFFFC, 4, "R1 large wrap", 0);
    fetch_one(23'd0, 4, "R1 large after wrap", 0);
  endtask

  task automatic t_swap();
    do_reset();
    ctl_sysmem = 1'b1;
    for (int m = 0; m < 4; m++) begin
      ctl_swap = 2'(m);
      write_wptr(23'(m + 1));
      fetch_one(23'(m), 1, "R5 swap", 0);
    end
    ctl_sysmem = 1'b0;
    ctl_swap = 2'd2;
    write_wptr(23'd5);
    fetch_one(23'd4, 1, "R6 local no swap", 0);
  endtask

  task automatic t_wb(input bit off);
    do_reset();
    ctl_blk_code = 6'd1;
    ctl_burst = 2'd3;
    ctl_wb_off = off;
    write_wptr(23'd10);
    fetch_one(23'd0, 10, off ? "R9 run" : "R8 run", 0);
    if (off) begin
      repeat (3) @(negedge clk);
      chk("R9 write-back suppressed", {31'b0, wb_valid}, 32'd0);
    end else begin
      chk("R8 wb_valid", {31'b0, wb_valid}, 32'd1);
      chk("R8 wb_ptr", 32'(wb_ptr), 32'd8);
      repeat (5) @(negedge clk);
      chk("R8 wb held", {31'b0, wb_valid}, 32'd1);
      wb_ready = 1'b1;
      @(negedge clk);
      wb_ready = 1'b0;
      chk("R8 wb cleared", {31'b0, wb_valid}, 32'd0);
    end
  endtask

  task automatic t_shadow();
    do_reset();
    write_shadow(23'd20);
    write_wptr(23'd3);
    chk("R10 no load when disabled", 32'(rptr_o), 32'd0);
    fetch_one(23'd0, 3, "R10 plain", 0);
    ctl_shadow_en = 1'b1;
    write_wptr(23'd25);
    chk("R10 shadow loaded", 32'(rptr_o), 32'd20);
    fetch_one(23'd20, 5, "R10 from shadow", 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_empty();
    t_basic();
    t_burst();
    t_clamp();
    t_swap();
    t_wb(1'b0);
    t_wb(1'b1);
    t_shadow();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule